// File: doc/BRIEF.md
# Wiper Register and Bank Controller

This block is the digital core behind a stepped potentiometer. It keeps an 8-bit wiper code register and a 16-entry byte store arranged as four banks of four. A serial command front end decodes host traffic into one operation per cycle. The block carries out that operation:

- read or write the wiper;
- read or write any stored byte;
- copy a bank 0 byte into the wiper, or the wiper into a bank 0 byte;
- move the wiper one step up or down, with saturation;
- report a write-in-progress flag.

Writes to the byte store stand in for slow nonvolatile writes. They are staged when the command arrives. They are committed only when the chip-select rise is signalled. A commit starts a busy period whose length is set by a parameter. A hardware protect input can block the commit.

At reset the byte store takes a parameterised default image. The wiper is then recalled from bank 0 entry 0 before any command is accepted. The wiper code reaches the output after a parameterised response delay. The code is presented both as an 8-bit value and as a one-hot tap select. Bit 0 of the tap select is the low terminal and bit 255 is the high terminal.

Top module: `wiper_bank_ctrl`

## Requirements
- R1: On reset the store holds the default image, in which entry a = 4*bank + slot holds (a*17 mod 256) XOR 80h. In the first cycle after reset the wiper is loaded from bank 0 slot 0, and ready rises. Commands are accepted only while ready is 1.
- R2: Command code 2 with bank 0 sets the wiper to cmd_data. Code 1 with bank 0 returns the wiper on rd_data, with rd_valid high, in the cycle after the command.
- R3: Any change of the wiper register appears on wiper_code exactly RESP_CYCLES clock edges after the edge that changed it.
- R4: tap_sel is one-hot at all times, and its set bit index equals wiper_code: 00h selects bit 0 and FFh selects bit 255.
- R5: Code 7 steps the wiper up by one and code 8 steps it down by one. Both need bank 0. The wiper stays at FFh when stepped up and at 00h when stepped down.
- R6: Code 4 stages cmd_data for entry {bank, slot} in any bank. The entry changes only on a later cs_rise pulse. Until then, code 3 still returns the old value.
- R7: A commit holds busy high for exactly NVW_CYCLES edges. Code 9 returns {7'b0, busy}.
- R8: While busy is 1, new staging requests (codes 4 and 6) are ignored, and so is a cs_rise. Reads and wiper operations still complete.
- R9: While wp_n is 0 at cs_rise, the staged write is dropped: no entry changes and busy stays 0.
- R10: Wiper operations (codes 1, 2, 5, 6, 7 and 8) with a bank other than 0 have no effect and return no data.
- R11: Code 5 with bank 0 copies entry slot into the wiper. Code 6 with bank 0 stages the current wiper value for entry slot, and it commits as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A decoded command is present |
| cmd_op | input | 4 | Command code (see requirements) |
| cmd_bank | input | 2 | Bank select |
| cmd_reg | input | 2 | Slot select within the bank |
| cmd_data | input | 8 | Write data |
| cs_rise | input | 1 | One-cycle pulse: chip select went high |
| wp_n | input | 1 | Write protect, low blocks commits |
| ready | output | 1 | Power-on recall finished |
| rd_valid | output | 1 | rd_data carries a read result |
| rd_data | output | 8 | Read result |
| busy | output | 1 | Nonvolatile write in progress |
| wiper_code | output | 8 | Settled wiper code |
| tap_sel | output | 256 | One-hot tap select |

## Verification
The wiper is driven by a vector table that mixes the following operations:
- direct loads;
- steps in both directions, including steps that run into each end;
- copies from bank 0;
- the same operations aimed at other banks.

A read-back after each vector tells a saturating step from a wrapping one, and an ignored off-bank command from an executed one. Directed sequences then check the following:
- The output lag is probed on the edge before the new code is due and on the edge it is due.
- The staged writes are read before and after the chip-select pulse, which separates staging from commit.
- The busy window is sampled at its last high edge and at its first low edge.
- Writes attempted during busy and under write protect are read back to show they left no trace.

// File: rtl/wb_pkg.sv
package wb_pkg;

  localparam int CODE_W = 8;
  localparam int N_BANK = 4;
  localparam int N_SLOT = 4;
  localparam int N_ENT  = N_BANK * N_SLOT;
  localparam int BANK_W = $clog2(N_BANK);
  localparam int SLOT_W = $clog2(N_SLOT);
  localparam int ADDR_W = BANK_W + SLOT_W;
  localparam int N_TAP  = 1 << CODE_W;

  typedef enum logic [3:0] {
    OP_NOP        = 4'd0,
    OP_RD_WIPER   = 4'd1,
    OP_WR_WIPER   = 4'd2,
    OP_RD_DATA    = 4'd3,
    OP_WR_DATA    = 4'd4,
    OP_LOAD_WIPER = 4'd5,
    OP_SAVE_WIPER = 4'd6,
    OP_STEP_UP    = 4'd7,
    OP_STEP_DN    = 4'd8,
    OP_RD_STATUS  = 4'd9
  } wb_op_e;

  // One saturating step of the wiper code.
  function automatic logic [CODE_W-1:0] step_code(input logic [CODE_W-1:0] c,
                                                  input logic up);
    logic [CODE_W-1:0] r;
    if (up) r = (c == {CODE_W{1'b1}}) ? c : c + 1'b1;
    else    r = (c == '0)             ? c : c - 1'b1;
    return r;
  endfunction

  // Default store image: entry a holds (a*17) xor 80h.
  function automatic logic [N_ENT*CODE_W-1:0] default_image();
    logic [N_ENT*CODE_W-1:0] img;
    img = '0;
    for (int i = 0; i < N_ENT; i++) begin
      img[i*CODE_W +: CODE_W] = CODE_W'(i * 17) ^ CODE_W'(8'h80);
    end
    return img;
  endfunction

endpackage

// File: rtl/wb_regfile.sv
module wb_regfile #(
  parameter int N_ENT = 16,
  parameter int W     = 8,
  parameter logic [N_ENT*W-1:0] INIT = '0,
  localparam int AW = $clog2(N_ENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  head
);

  logic [W-1:0] mem [N_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++) mem[e] <= INIT[e*W +: W];
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
  assign head  = mem[0];

endmodule

// File: rtl/wb_nv_timer.sv
module wb_nv_timer #(
  parameter int CYCLES = 1000000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/wb_wiper.sv
module wb_wiper #(
  parameter int W    = 8,
  parameter int RESP = 1000,
  localparam int SW = $clog2(RESP + 1),
  localparam int NT = 1 << W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  output logic [W-1:0]  wcr,
  output logic [W-1:0]  code,
  output logic [NT-1:0] tap,
  output logic [SW-1:0] settle
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcr    <= '0;
      code   <= '0;
      settle <= '0;
    end else begin
      if (load) begin
        wcr    <= load_val;
        settle <= SW'(RESP);
      end else if (settle != '0) begin
        settle <= settle - 1'b1;
      end
      if (settle == SW'(1)) code <= wcr;
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_tap
    assign tap[t] = (code == W'(t));
  end

endmodule

// File: rtl/wiper_bank_ctrl.sv
module wiper_bank_ctrl #(
  parameter int NVW_CYCLES  = 1000000,
  parameter int RESP_CYCLES = 1000,
  parameter logic [wb_pkg::N_ENT*wb_pkg::CODE_W-1:0] INIT_IMAGE = wb_pkg::default_image()
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [3:0]   cmd_op,
  input  logic [1:0]   cmd_bank,
  input  logic [1:0]   cmd_reg,
  input  logic [7:0]   cmd_data,
  input  logic         cs_rise,
  input  logic         wp_n,
  output logic         ready,
  output logic         rd_valid,
  output logic [7:0]   rd_data,
  output logic         busy,
  output logic [7:0]   wiper_code,
  output logic [255:0] tap_sel
);
  import wb_pkg::*;

  localparam int SW = $clog2(RESP_CYCLES + 1);

  wb_op_e op;
  assign op = wb_op_e'(cmd_op);

  logic go, bank0;
  logic [ADDR_W-1:0] addr;
  assign go    = cmd_valid && ready;
  assign bank0 = (cmd_bank == '0);
  assign addr  = {cmd_bank, cmd_reg};

  logic [CODE_W-1:0] rf_rdata, rf_head, wcr;
  logic [SW-1:0]     settle;

  // wiper load path
  logic              w_load;
  logic [CODE_W-1:0] w_val;
  logic              step_up_fire, step_dn_fire;
  assign step_up_fire = go && bank0 && (op == OP_STEP_UP);
  assign step_dn_fire = go && bank0 && (op == OP_STEP_DN);

  always_comb begin
    w_load = 1'b0;
    w_val  = wcr;
    if (!ready) begin
      w_load = 1'b1;
      w_val  = rf_head;
    end else if (go && bank0) begin
      unique case (op)
        OP_WR_WIPER:   begin w_load = 1'b1; w_val = cmd_data;            end
        OP_LOAD_WIPER: begin w_load = 1'b1; w_val = rf_rdata;            end
        OP_STEP_UP:    begin w_load = 1'b1; w_val = step_code(wcr, 1'b1); end
        OP_STEP_DN:    begin w_load = 1'b1; w_val = step_code(wcr, 1'b0); end
        default:       ;
      endcase
    end
  end

  // staging and commit of store writes
  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;
  logic [CODE_W-1:0] pend_data;
  logic              arm_fire, commit_fire, rf_we;

  assign arm_fire = go && !busy &&
                    ((op == OP_WR_DATA) || ((op == OP_SAVE_WIPER) && bank0));
  assign commit_fire = cs_rise && pend_v && wp_n && !busy;
  assign rf_we       = commit_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (arm_fire) begin
      pend_v    <= 1'b1;
      pend_addr <= addr;
      pend_data <= (op == OP_WR_DATA) ? cmd_data : wcr;
    end else if (cs_rise) begin
      pend_v    <= 1'b0;
    end
  end

  // recall sequencing and read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      ready    <= 1'b1;
      rd_valid <= 1'b0;
      if (go) begin
        unique case (op)
          OP_RD_DATA:   begin rd_valid <= 1'b1;  rd_data <= rf_rdata;              end
          OP_RD_STATUS: begin rd_valid <= 1'b1;  rd_data <= {{(CODE_W-1){1'b0}}, busy}; end
          OP_RD_WIPER:  begin rd_valid <= bank0; if (bank0) rd_data <= wcr;        end
          default:      ;
        endcase
      end
    end
  end

  wb_regfile #(.N_ENT(N_ENT), .W(CODE_W), .INIT(INIT_IMAGE)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(pend_addr), .wdata(pend_data),
    .raddr(addr), .rdata(rf_rdata), .head(rf_head)
  );

  wb_nv_timer #(.CYCLES(NVW_CYCLES)) u_nvt (
    .clk(clk), .rst_n(rst_n), .start(commit_fire), .busy(busy)
  );

  wb_wiper #(.W(CODE_W), .RESP(RESP_CYCLES)) u_wip (
    .clk(clk), .rst_n(rst_n), .load(w_load), .load_val(w_val),
    .wcr(wcr), .code(wiper_code), .tap(tap_sel), .settle(settle)
  );

endmodule

// File: rtl/wb_checker.sv
module wb_checker #(
  parameter int SW = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         rf_we,
  input logic         wp_n,
  input logic         cs_rise,
  input logic         commit_fire,
  input logic [255:0] tap_sel,
  input logic [7:0]   wiper_code,
  input logic [7:0]   wcr,
  input logic         step_up_fire,
  input logic         step_dn_fire,
  input logic [SW-1:0] settle
);

  // R7
  commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> busy);

  // R8
  busy_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rf_we);

  // R9
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |-> !rf_we);

  // R6
  commit_on_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> cs_rise);

  // R4
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);

  // R5
  sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up_fire && wcr == 8'hFF) |=> wcr == 8'hFF);

  // R5
  sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn_fire && wcr == 8'h00) |=> wcr == 8'h00);

  // R3
  lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_code) |-> $past(settle) == SW'(1));

endmodule

bind wiper_bank_ctrl wb_checker #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rf_we(rf_we), .wp_n(wp_n),
  .cs_rise(cs_rise), .commit_fire(commit_fire), .tap_sel(tap_sel),
  .wiper_code(wiper_code), .wcr(wcr), .step_up_fire(step_up_fire),
  .step_dn_fire(step_dn_fire), .settle(settle)
);

// File: tb/sim_wiper_bank_ctrl.sv
`timescale 1ns/1ps
module sim_wiper_bank_ctrl;

  localparam int NVW  = 20;
  localparam int RESP = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [3:0]   cmd_op = '0;
  logic [1:0]   cmd_bank = '0;
  logic [1:0]   cmd_reg = '0;
  logic [7:0]   cmd_data = '0;
  logic         cs_rise = 1'b0;
  logic         wp_n = 1'b1;
  logic         ready, rd_valid, busy;
  logic [7:0]   rd_data, wiper_code;
  logic [255:0] tap_sel;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wiper_bank_ctrl #(.NVW_CYCLES(NVW), .RESP_CYCLES(RESP)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
    .cs_rise(cs_rise), .wp_n(wp_n), .ready(ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy), .wiper_code(wiper_code), .tap_sel(tap_sel)
  );

  function automatic logic [7:0] img(input int a);
    return 8'((a * 17) % 256) ^ 8'h80;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [3:0] op, input logic [1:0] b,
                        input logic [1:0] r, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bank = b; cmd_reg = r; cmd_data = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
  endtask

  task automatic pulse_cs();
    @(negedge clk);
    cs_rise = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cs_rise = 1'b0;
  endtask

  task automatic read_chk(input logic [3:0] op, input logic [1:0] b,
                          input logic [1:0] r, input logic [7:0] exp, input string tag);
    do_cmd(op, b, r, 8'h00);
    chk(rd_valid === 1'b1 && rd_data === exp, tag, rd_data, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
  endtask

  // {op, bank, slot, data, expected wiper}
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {4'd2, 2'd0, 2'd0, 8'h10, 8'h10},
    {4'd7, 2'd0, 2'd0, 8'h00, 8'h11},
    {4'd8, 2'd0, 2'd0, 8'h00, 8'h10},
    {4'd2, 2'd0, 2'd0, 8'hFE, 8'hFE},
    {4'd7, 2'd0, 2'd0, 8'h00, 8'hFF},
    {4'd7, 2'd0, 2'd0, 8'h00, 8'hFF},
    {4'd2, 2'd0, 2'd0, 8'h01, 8'h01},
    {4'd8, 2'd0, 2'd0, 8'h00, 8'h00},
    {4'd8, 2'd0, 2'd0, 8'h00, 8'h00},
    {4'd2, 2'd1, 2'd0, 8'h55, 8'h00},
    {4'd7, 2'd2, 2'd0, 8'h00, 8'h00},
    {4'd5, 2'd0, 2'd2, 8'h00, 8'hA2},
    {4'd5, 2'd3, 2'd1, 8'h00, 8'hA2}
  };

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready === 1'b0 && rd_valid === 1'b0 && busy === 1'b0, "R1 reset state", ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready === 1'b1, "R1 ready after recall", ready, 1);
    repeat (RESP) @(negedge clk);
    chk(wiper_code === 8'h80, "R1 recalled wiper_code", wiper_code, 8'h80);
    chk(tap_sel[128] === 1'b1 && $countones(tap_sel) == 1, "R4 tap at 80h", $countones(tap_sel), 1);
    read_chk(4'd1, 2'd0, 2'd0, 8'h80, "R1 R2 read wiper after recall");
    read_chk(4'd3, 2'd3, 2'd3, img(15), "R1 default bank3 slot3");
    read_chk(4'd3, 2'd1, 2'd2, img(6), "R1 default bank1 slot2");

    // vector table: R2 R5 R10 R11
    for (int v = 0; v < NV; v++) begin
      do_cmd(VEC[v][23:20], VEC[v][19:18], VEC[v][17:16], VEC[v][15:8]);
      do_cmd(4'd1, 2'd0, 2'd0, 8'h00);
      chk(rd_valid === 1'b1 && rd_data === VEC[v][7:0],
          $sformatf("R2 R5 R10 R11 vector %0d", v), rd_data, VEC[v][7:0]);
    end
    do_cmd(4'd1, 2'd2, 2'd0, 8'h00);
    chk(rd_valid === 1'b0, "R10 off-bank wiper read gives no data", rd_valid, 0);

    // R3 output lag
    repeat (RESP + 2) @(negedge clk);
    do_cmd(4'd2, 2'd0, 2'd0, 8'h40);
    repeat (RESP - 1) @(negedge clk);
    chk(wiper_code === 8'hA2, "R3 old code one edge early", wiper_code, 8'hA2);
    @(negedge clk);
    chk(wiper_code === 8'h40, "R3 new code on time", wiper_code, 8'h40);
    chk(tap_sel[64] === 1'b1 && $countones(tap_sel) == 1, "R4 tap at 40h", $countones(tap_sel), 1);

    // R4 ends
    do_cmd(4'd2, 2'd0, 2'd0, 8'hFF);
    repeat (RESP) @(negedge clk);
    chk(tap_sel[255] === 1'b1 && $countones(tap_sel) == 1, "R4 high terminal", tap_sel[255], 1);
    do_cmd(4'd2, 2'd0, 2'd0, 8'h00);
    repeat (RESP) @(negedge clk);
    chk(tap_sel[0] === 1'b1 && $countones(tap_sel) == 1, "R4 low terminal", tap_sel[0], 1);

    // R6 R7 staged write and busy window
    do_cmd(4'd4, 2'd2, 2'd1, 8'h3C);
    read_chk(4'd3, 2'd2, 2'd1, img(9), "R6 old value before cs_rise");
    chk(busy === 1'b0, "R6 no busy before cs_rise", busy, 0);
    pulse_cs();
    chk(busy === 1'b1, "R7 busy after commit", busy, 1);
    repeat (NVW - 1) @(negedge clk);
    chk(busy === 1'b1, "R7 busy on last edge", busy, 1);
    @(negedge clk);
    chk(busy === 1'b0, "R7 busy clears after NVW edges", busy, 0);
    read_chk(4'd3, 2'd2, 2'd1, 8'h3C, "R6 committed value");
    read_chk(4'd9, 2'd0, 2'd0, 8'h00, "R7 status idle");

    // R8 requests during busy
    do_cmd(4'd4, 2'd1, 2'd0, 8'h77);
    pulse_cs();
    read_chk(4'd9, 2'd0, 2'd0, 8'h01, "R7 status busy");
    do_cmd(4'd4, 2'd1, 2'd1, 8'h11);
    pulse_cs();
    read_chk(4'd3, 2'd1, 2'd1, img(5), "R8 write during busy ignored");
    do_cmd(4'd2, 2'd0, 2'd0, 8'h33);
    read_chk(4'd1, 2'd0, 2'd0, 8'h33, "R8 wiper op during busy");
    wait_idle();
    pulse_cs();
    chk(busy === 1'b0, "R8 ignored request not retained", busy, 0);
    read_chk(4'd3, 2'd1, 2'd0, 8'h77, "R8 first write landed");
    read_chk(4'd3, 2'd1, 2'd1, img(5), "R8 second write absent");

    // R9 write protect
    wp_n = 1'b0;
    do_cmd(4'd4, 2'd0, 2'd1, 8'h99);
    pulse_cs();
    chk(busy === 1'b0, "R9 no busy under protect", busy, 0);
    read_chk(4'd3, 2'd0, 2'd1, img(1), "R9 entry unchanged");
    wp_n = 1'b1;

    // R11 save wiper to bank 0, and off-bank save ignored (R10)
    do_cmd(4'd2, 2'd0, 2'd0, 8'h5A);
    do_cmd(4'd6, 2'd0, 2'd3, 8'h00);
    pulse_cs();
    chk(busy === 1'b1, "R11 save commits", busy, 1);
    wait_idle();
    read_chk(4'd3, 2'd0, 2'd3, 8'h5A, "R11 saved wiper value");
    do_cmd(4'd6, 2'd2, 2'd0, 8'h00);
    pulse_cs();
    chk(busy === 1'b0, "R10 off-bank save no commit", busy, 0);
    read_chk(4'd3, 2'd2, 2'd0, img(8), "R10 off-bank save left entry");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule